// File: doc/BRIEF.md
# Staircase Edge Weight Generator

This block produces the nonlinear weight that scales one filtering direction of an edge-preserving noise smoother. It takes two 8-bit control pixels and forms their absolute difference. Seven parallel comparators place that difference in one of eight intervals, and the intervals are packed toward small differences. The interval number then indexes a 6-bit weight in one of six tables. This staircase stands in for the curve 1/(1+K·d²), so the block has no divider and no squarer.

The caller chooses the table with a noise-class code and a spatial/temporal flag. The tables can be reloaded word by word through a write port. One lookup can be issued per clock, and each result appears one cycle after its request.

Top module: `edge_wgt_lut`

## Requirements
- R1: While reset is held and immediately after it, `wgt_valid` is 0, `wgt` is 0, and every table holds the default weights.
- R2: The weight depends only on |pix_a - pix_b|. Swapping the two pixels gives the same result.
- R3: The interval index is the largest k such that the difference is at least the k-th lower edge. The lower edges are 0, 8, 16, 24, 32, 48, 64 and 128, for k = 0 to 7.
- R4: After reset, every table holds the weights 63, 53, 43, 32, 21, 13, 6 and 2 for intervals 0 to 7. Unity weight is stored as 63.
- R5: The table index is 2·class + temporal. Class codes are 0 Gaussian, 1 contaminated Gaussian and 2 impulsive. Class code 3 is treated as 2.
- R6: `wgt_valid` is high exactly one cycle after `req_valid` was high. `wgt` then holds the lookup result for that request.
- R7: While no request is issued, `wgt` keeps its last value.
- R8: A write with `wr_en` stores `wr_data` at address {table[5:3], interval[2:0]}. Lookups from the next cycle onward see the new word. A lookup issued in the same cycle as the write reads the old word.
- R9: A write whose table field is 6 or 7 changes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| pix_a | input | 8 | First control pixel |
| pix_b | input | 8 | Second control pixel |
| noise_cls | input | 2 | Noise class code |
| temporal | input | 1 | 1 selects the temporal table, 0 the spatial table |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | {table, interval} write address |
| wr_data | input | 6 | Weight word to write |
| wgt_valid | output | 1 | Weight valid |
| wgt | output | 6 | Weight in 64ths |

## Verification
A wrong table word stays invisible until a lookup lands on that exact table and interval. For that reason the bench reads back every word of every table after each write phase. A wrong comparator edge shows only for differences at or just below that edge, so every edge is probed on both sides. A wrong table index or interval index shows on the very next `wgt_valid` cycle as a value that differs from the scoreboard.

// File: rtl/edge_wgt_lut.sv
module edge_wgt_lut #(
  parameter int PIX_W    = 8,
  parameter int WGT_W    = 6,
  parameter int N_BINS   = 8,
  parameter int N_TABLES = 6
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  input  logic [PIX_W-1:0]                          pix_a,
  input  logic [PIX_W-1:0]                          pix_b,
  input  logic [1:0]                                noise_cls,
  input  logic                                      temporal,
  input  logic                                      wr_en,
  input  logic [$clog2(N_TABLES)+$clog2(N_BINS)-1:0] wr_addr,
  input  logic [WGT_W-1:0]                          wr_data,
  output logic                                      wgt_valid,
  output logic [WGT_W-1:0]                          wgt
);
  localparam int BW   = $clog2(N_BINS);
  localparam int TW   = $clog2(N_TABLES);
  localparam int MEMW = N_TABLES * N_BINS * WGT_W;

  function automatic logic [PIX_W-1:0] lo_edge(input int k);
    int v;
    if (k <= 4)      v = 8 * k;
    else if (k == 5) v = 48;
    else if (k == 6) v = 64;
    else             v = 128;
    return PIX_W'(v);
  endfunction

  function automatic logic [WGT_W-1:0] dflt(input int k);
    int v;
    case (k)
      0: v = 63;  1: v = 53;  2: v = 43;  3: v = 32;
      4: v = 21;  5: v = 13;  6: v = 6;   default: v = 2;
    endcase
    return WGT_W'(v);
  endfunction

  logic [MEMW-1:0]   mem;
  logic [PIX_W-1:0]  diff;
  logic [N_BINS-1:1] ge;
  logic [BW-1:0]     bin;
  logic [1:0]        cls_eff;
  logic [TW-1:0]     tidx, wtbl;
  int                rd_base, wr_base;

  assign diff    = (pix_a >= pix_b) ? pix_a - pix_b : pix_b - pix_a;
  assign cls_eff = (noise_cls == 2'd3) ? 2'd2 : noise_cls;
  assign tidx    = TW'({cls_eff, temporal});
  assign wtbl    = wr_addr[TW+BW-1:BW];

  for (genvar k = 1; k < N_BINS; k++) begin : g_cmp
    assign ge[k] = diff >= lo_edge(k);
  end

  always_comb begin
    bin = '0;
    for (int k = 1; k < N_BINS; k++)
      if (ge[k]) bin = BW'(k);
  end

  assign rd_base = (int'(tidx) * N_BINS + int'(bin)) * WGT_W;
  assign wr_base = int'(wr_addr) * WGT_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < N_TABLES; t++)
        for (int e = 0; e < N_BINS; e++)
          mem[(t*N_BINS+e)*WGT_W +: WGT_W] <= dflt(e);
    end else if (wr_en && int'(wtbl) < N_TABLES) begin
      mem[wr_base +: WGT_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgt_valid <= 1'b0;
      wgt       <= '0;
    end else begin
      wgt_valid <= req_valid;
      if (req_valid) wgt <= mem[rd_base +: WGT_W];
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> wgt_valid);
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !wgt_valid);
  assert_weight_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(wgt));
  assert_bad_table_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wtbl) >= N_TABLES) |=> $stable(mem));
endmodule

// File: tb/tb_edge_wgt_lut.sv
module tb_edge_wgt_lut;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, temporal = 0, wr_en = 0;
  logic [7:0] pix_a = 0, pix_b = 0;
  logic [1:0] noise_cls = 0;
  logic [5:0] wr_addr = 0, wr_data = 0;
  logic       wgt_valid;
  logic [5:0] wgt;

  int n_chk = 0, n_bad = 0;
  logic [5:0] model [6][8];
  logic [5:0] expq [$];
  string      tagq [$];
  logic [5:0] last_exp;
  bit         running = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_wgt_lut dut (.*);

  function automatic int ebin(int d);
    if (d >= 128) return 7;
    if (d >= 64)  return 6;
    if (d >= 48)  return 5;
    if (d >= 32)  return 4;
    if (d >= 24)  return 3;
    if (d >= 16)  return 2;
    if (d >= 8)   return 1;
    return 0;
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int a, int b, int cls, bit tmp,
                      bit we, int waddr, int wdata, string tag);
    int d, t;
    req_valid = v; pix_a = 8'(a); pix_b = 8'(b);
    noise_cls = 2'(cls); temporal = tmp;
    wr_en = we; wr_addr = 6'(waddr); wr_data = 6'(wdata);
    if (v) begin
      d = (a > b) ? a - b : b - a;
      t = (cls == 3 ? 2 : cls) * 2 + int'(tmp);
      expq.push_back(model[t][ebin(d)]);
      tagq.push_back(tag);
    end
    if (we && (waddr >> 3) < 6) model[waddr >> 3][waddr & 7] = 6'(wdata);
    @(negedge clk);
  endtask

  task automatic look(int a, int b, int cls, bit tmp, string tag);
    step(1, a, b, cls, tmp, 0, 0, 0, tag);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic sweep_all(string tag);
    for (int c = 0; c < 3; c++)
      for (int tm = 0; tm < 2; tm++)
        for (int e = 0; e < 8; e++) begin
          int edges [8] = '{0, 8, 16, 24, 32, 48, 64, 128};
          look(100, 100 + edges[e], c, tm[0], tag);
        end
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (wgt_valid) begin
        if (expq.size() == 0) check("R6 unexpected valid", 1, 0);
        else begin
          last_exp = expq.pop_front();
          check(tagq.pop_front(), wgt, last_exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int edges [8] = '{0, 8, 16, 24, 32, 48, 64, 128};
    int dv [8]    = '{63, 53, 43, 32, 21, 13, 6, 2};
    for (int t = 0; t < 6; t++)
      for (int e = 0; e < 8; e++) model[t][e] = 6'(dv[e]);
    repeat (3) @(negedge clk);
    check("R1 reset valid", 6'(wgt_valid), 0);
    check("R1 reset weight", wgt, 0);
    rst_n = 1;
    @(negedge clk);
    running = 1;
    check("R1 valid after reset", 6'(wgt_valid), 0);
    // R3/R4: every edge and the value just below it
    for (int e = 0; e < 8; e++) begin
      look(edges[e], 0, 0, 0, "R3 R4 at edge");
      if (e > 0) look(0, edges[e] - 1, 0, 0, "R3 below edge");
    end
    look(255, 0, 1, 1, "R3 max diff");
    // R2 symmetry
    look(200, 37, 2, 0, "R2 a>b");
    look(37, 200, 2, 0, "R2 b>a");
    look(90, 70, 1, 0, "R2 a>b");
    look(70, 90, 1, 0, "R2 b>a");
    // R8: distinct contents per table
    for (int t = 0; t < 6; t++)
      for (int e = 0; e < 8; e++)
        step(0, 0, 0, 0, 0, 1, t*8+e, (t*8+e) ^ 6'h2a, "");
    sweep_all("R5 R8 table select");
    look(0, 130, 3, 0, "R5 class3 spatial");
    look(20, 0, 3, 1, "R5 class3 temporal");
    // R8 collision: same-cycle lookup reads old word
    step(1, 0, 50, 1, 1, 1, 3*8+5, 7, "R8 same-cycle old word");
    look(0, 50, 1, 1, "R8 next-cycle new word");
    // R9: writes to tables 6 and 7 change nothing
    for (int e = 0; e < 8; e++) begin
      step(0, 0, 0, 0, 0, 1, 48+e, 0, "");
      step(0, 0, 0, 0, 0, 1, 56+e, 1, "");
    end
    sweep_all("R9 tables untouched");
    // R6/R7: back-to-back, then hold
    look(0, 9, 0, 0, "R6 back-to-back");
    look(0, 200, 0, 1, "R6 back-to-back");
    idle();
    check("R6 valid low after gap", 6'(wgt_valid), 0);
    step(0, 0, 255, 2, 1, 0, 0, 0, "");
    idle();
    check("R7 weight held", wgt, last_exp);
    check("R6 no valid while idle", 6'(wgt_valid), 0);
    check("R6 queue drained", 6'(expq.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule